// File: doc/BRIEF.md
# Vectored Interrupt Controller with Shared Vector

This block collects interrupt events for a small 8-bit processor core and turns them into a single subroutine-call request carrying a fixed vector address. Two timers each own a private vector. A third timer and a periodic time-base tick share one multi-function vector. Each event pulse latches a request flag. A request is offered to the core only when the master enable is set, the call stack has room, and the source's own enable is set. The request and its vector are held until the core accepts them.

On acceptance, the controller blocks nesting by clearing the master enable. A private-vector source also loses its flag in the same clock cycle. For the shared vector, only the aggregate flag is cleared. The two sub-source flags stay set, so software can tell which one fired, and software must clear them itself. All enables and flags can be read and written through a byte-wide register port. Writing a flag to one forces a request.

The sequencing is handled by a two-state machine. In `ST_IDLE` no request is shown. The transition *launch* moves to `ST_OFFER` when an eligible request exists; the winning vector is latched at that point. In `ST_OFFER` the request and vector are driven. The transition *accept* returns to `ST_IDLE` when the core acknowledges, and applies the entry-time clears.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, every enable and flag reads as zero at both register addresses, and `irq_req` is low.
- R2: Register address 0 holds these bits: bit0 master enable, bit1 timer-0 enable, bit2 timer-1 enable, bit3 shared-vector enable, bit4 timer-0 flag, bit5 timer-1 flag, bit6 shared aggregate flag; bit7 reads zero. A one-cycle pulse on `t0_ovf` or `t1_ovf` sets that timer's flag, whatever the enables are. The flag stays set until hardware entry clears it or software writes it. A software write can set or clear any flag.
- R3: Register address 1 holds these bits: bit0 timer-2 enable, bit1 time-base enable, bit4 timer-2 flag, bit5 time-base flag; all other bits read zero. A pulse on `t2_ovf` or `tb_tick` always sets its own flag. It also sets the aggregate flag (address 0, bit6), but only when both the shared-vector enable and that sub-source's enable are set.
- R4: A request is raised only when three conditions hold together: the master enable is set, `stack_full` is low, and at least one source has both its flag and its enable set. `irq_req` rises on the clock edge after the flag becomes visible.
- R5: The vector presented is 0x00C for timer 0, 0x010 for timer 1 and 0x018 for the shared vector.
- R6: When more than one source is eligible, the priority is timer 0 first, then timer 1, then the shared vector.
- R7: While `irq_ack` is low, `irq_req` and `irq_vec` stay unchanged.
- R8: At the edge where `irq_ack` is high while a request is offered, the request drops, the master enable clears, and the flag of a private-vector source clears.
- R9: Accepting the shared vector clears only the aggregate flag. The timer-2 and time-base flags stay set until software writes them to zero. With the aggregate flag cleared, they raise no new request.
- R10: If the master enable is set again while a flag and its enable are still set, `irq_req` rises on the next clock edge.
- R11: If an event pulse arrives in the same cycle as a register write that clears its flag, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| t0_ovf | input | 1 | Timer 0 overflow pulse |
| t1_ovf | input | 1 | Timer 1 overflow pulse |
| t2_ovf | input | 1 | Timer 2 overflow pulse (shared vector) |
| tb_tick | input | 1 | Time-base time-out pulse (shared vector) |
| stack_full | input | 1 | Call stack has no free entry |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address (0 or 1) |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data, combinational on `reg_addr` |
| irq_req | output | 1 | Subroutine-call request to the core |
| irq_vec | output | VEC_W | Call target address |
| irq_ack | input | 1 | Core accepts the offered request |

## Verification
The bench builds the block with its default parameters: an 8-bit data path, a 2-bit register address and 12-bit vectors holding 0x00C, 0x010 and 0x018. With these values it can compare `irq_vec` directly against the three fixed call addresses. Both register addresses are reachable, so the sub-source flags and the aggregate flag can be observed separately before and after an acceptance. Because the vectors are narrow, the priority ordering and the hold-until-accept behaviour can be watched on every cycle of an offer.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;

    localparam int NUM_SRC = 3;
    localparam int SRC_T0  = 0;
    localparam int SRC_T1  = 1;
    localparam int SRC_MF  = 2;

    // address 0 layout
    localparam int B_GIE = 0;
    localparam int B_T0E = 1;
    localparam int B_T1E = 2;
    localparam int B_MFE = 3;
    localparam int B_T0F = 4;
    localparam int B_T1F = 5;
    localparam int B_MFF = 6;

    // address 1 layout
    localparam int B_T2E = 0;
    localparam int B_TBE = 1;
    localparam int B_T2F = 4;
    localparam int B_TBF = 5;

    localparam int ADR_MAIN = 0;
    localparam int ADR_MF   = 1;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_OFFER = 1'b1
    } irq_state_e;

endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
    import irq_vec_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ev_t0,
    input  logic                ev_t1,
    input  logic                ev_t2,
    input  logic                ev_tb,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W-1:0]   wdata,
    output logic [DATA_W-1:0]   rdata,
    input  logic                hw_clr_gie,
    input  logic [NUM_SRC-1:0]  hw_clr_src,
    output logic                gie,
    output logic [NUM_SRC-1:0]  src_en,
    output logic [NUM_SRC-1:0]  src_flag
);

    localparam int NUM_DIR = 2;

    logic wr_main;
    logic wr_mf;
    logic [NUM_DIR-1:0] ev_dir;
    logic [NUM_DIR-1:0] den;
    logic [NUM_DIR-1:0] dfl;

    logic gie_q;
    logic mfe_q, mff_q;
    logic t2e_q, tbe_q, t2f_q, tbf_q;
    logic mf_hit;

    assign wr_main = wr_en && (addr == ADDR_W'(ADR_MAIN));
    assign wr_mf   = wr_en && (addr == ADDR_W'(ADR_MF));
    assign ev_dir  = {ev_t1, ev_t0};

    // private-vector sources: same structure per timer
    for (genvar i = 0; i < NUM_DIR; i++) begin : g_dir
        logic en_q;
        logic fl_q;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                en_q <= 1'b0;
                fl_q <= 1'b0;
            end else begin
                if (wr_main) begin
                    en_q <= wdata[B_T0E + i];
                    fl_q <= wdata[B_T0F + i];
                end
                if (hw_clr_src[i]) fl_q <= 1'b0;
                if (ev_dir[i])     fl_q <= 1'b1;
            end
        end
        assign den[i] = en_q;
        assign dfl[i] = fl_q;
    end

    assign mf_hit = mfe_q && ((ev_t2 && t2e_q) || (ev_tb && tbe_q));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gie_q <= 1'b0;
            mfe_q <= 1'b0;
            mff_q <= 1'b0;
        end else begin
            if (wr_main) begin
                gie_q <= wdata[B_GIE];
                mfe_q <= wdata[B_MFE];
                mff_q <= wdata[B_MFF];
            end
            if (hw_clr_gie)         gie_q <= 1'b0;
            if (hw_clr_src[SRC_MF]) mff_q <= 1'b0;
            if (mf_hit)             mff_q <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t2e_q <= 1'b0;
            tbe_q <= 1'b0;
            t2f_q <= 1'b0;
            tbf_q <= 1'b0;
        end else begin
            if (wr_mf) begin
                t2e_q <= wdata[B_T2E];
                tbe_q <= wdata[B_TBE];
                t2f_q <= wdata[B_T2F];
                tbf_q <= wdata[B_TBF];
            end
            if (ev_t2) t2f_q <= 1'b1;
            if (ev_tb) tbf_q <= 1'b1;
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(ADR_MAIN)) begin
            rdata[B_GIE] = gie_q;
            rdata[B_T0E] = den[0];
            rdata[B_T1E] = den[1];
            rdata[B_MFE] = mfe_q;
            rdata[B_T0F] = dfl[0];
            rdata[B_T1F] = dfl[1];
            rdata[B_MFF] = mff_q;
        end else if (addr == ADDR_W'(ADR_MF)) begin
            rdata[B_T2E] = t2e_q;
            rdata[B_TBE] = tbe_q;
            rdata[B_T2F] = t2f_q;
            rdata[B_TBF] = tbf_q;
        end
    end

    assign gie      = gie_q;
    assign src_en   = {mfe_q, den};
    assign src_flag = {mff_q, dfl};

    // R9
    mf_subflag_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_clr_src[SRC_MF] && t2f_q && !wr_mf) |=> t2f_q);

    // R3
    agg_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(mff_q) && !$past(wr_main)) |-> $past(mfe_q));

    // R11
    event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_t1 |=> dfl[SRC_T1]);

endmodule

// File: rtl/irq_prio_sel.sv
module irq_prio_sel
    import irq_vec_pkg::*;
#(
    parameter int          VEC_W  = 12,
    parameter logic [11:0] VEC_T0 = 12'h00C,
    parameter logic [11:0] VEC_T1 = 12'h010,
    parameter logic [11:0] VEC_MF = 12'h018
) (
    input  logic [NUM_SRC-1:0] pend,
    output logic [NUM_SRC-1:0] grant,
    output logic               any,
    output logic [VEC_W-1:0]   vec
);

    logic [VEC_W-1:0] vtab [NUM_SRC];

    assign vtab[SRC_T0] = VEC_W'(VEC_T0);
    assign vtab[SRC_T1] = VEC_W'(VEC_T1);
    assign vtab[SRC_MF] = VEC_W'(VEC_MF);

    // lowest index wins
    always_comb begin
        grant = '0;
        vec   = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (pend[i]) begin
                grant    = '0;
                grant[i] = 1'b1;
                vec      = vtab[i];
            end
        end
    end

    assign any = |pend;

endmodule

// File: rtl/irq_issue_fsm.sv
module irq_issue_fsm
    import irq_vec_pkg::*;
#(
    parameter int VEC_W = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               gie,
    input  logic               stack_full,
    input  logic               any,
    input  logic [NUM_SRC-1:0] grant,
    input  logic [VEC_W-1:0]   vec_in,
    input  logic               ack,
    output logic               irq_req,
    output logic [VEC_W-1:0]   irq_vec,
    output logic               clr_gie,
    output logic [NUM_SRC-1:0] clr_src
);

    irq_state_e         state_q, state_d;
    logic [NUM_SRC-1:0] sel_q;
    logic [VEC_W-1:0]   vec_q;
    logic               launch;

    assign launch = gie && !stack_full && any;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (launch) state_d = ST_OFFER;
            ST_OFFER: if (ack)    state_d = ST_IDLE;
            default:              state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            sel_q   <= '0;
            vec_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && launch) begin
                sel_q <= grant;
                vec_q <= vec_in;
            end
        end
    end

    always_comb begin
        irq_req = 1'b0;
        clr_gie = 1'b0;
        clr_src = '0;
        unique case (state_q)
            ST_IDLE: ;
            ST_OFFER: begin
                irq_req = 1'b1;
                if (ack) begin
                    clr_gie = 1'b1;
                    clr_src = sel_q;
                end
            end
            default: ;
        endcase
    end

    assign irq_vec = vec_q;

    // R7
    offer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && !ack) |=> (irq_req && $stable(irq_vec)));

    // R4
    launch_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_req) |-> $past(gie && !stack_full && any));

    // R8
    accept_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && ack) |=> !irq_req);

endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
    import irq_vec_pkg::*;
#(
    parameter int          DATA_W = 8,
    parameter int          ADDR_W = 2,
    parameter int          VEC_W  = 12,
    parameter logic [11:0] VEC_T0 = 12'h00C,
    parameter logic [11:0] VEC_T1 = 12'h010,
    parameter logic [11:0] VEC_MF = 12'h018
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              t0_ovf,
    input  logic              t1_ovf,
    input  logic              t2_ovf,
    input  logic              tb_tick,
    input  logic              stack_full,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq_req,
    output logic [VEC_W-1:0]  irq_vec,
    input  logic              irq_ack
);

    logic               gie;
    logic [NUM_SRC-1:0] src_en, src_flag, pend, grant, clr_src;
    logic               any, clr_gie;
    logic [VEC_W-1:0]   sel_vec;

    irq_flag_bank #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .ev_t0      (t0_ovf),
        .ev_t1      (t1_ovf),
        .ev_t2      (t2_ovf),
        .ev_tb      (tb_tick),
        .wr_en      (reg_wr),
        .addr       (reg_addr),
        .wdata      (reg_wdata),
        .rdata      (reg_rdata),
        .hw_clr_gie (clr_gie),
        .hw_clr_src (clr_src),
        .gie        (gie),
        .src_en     (src_en),
        .src_flag   (src_flag)
    );

    assign pend = src_en & src_flag;

    irq_prio_sel #(.VEC_W(VEC_W), .VEC_T0(VEC_T0), .VEC_T1(VEC_T1), .VEC_MF(VEC_MF)) u_sel (
        .pend  (pend),
        .grant (grant),
        .any   (any),
        .vec   (sel_vec)
    );

    irq_issue_fsm #(.VEC_W(VEC_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .gie        (gie),
        .stack_full (stack_full),
        .any        (any),
        .grant      (grant),
        .vec_in     (sel_vec),
        .ack        (irq_ack),
        .irq_req    (irq_req),
        .irq_vec    (irq_vec),
        .clr_gie    (clr_gie),
        .clr_src    (clr_src)
    );

    // R6
    grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant) && (any == (grant != '0)));

    // R6
    t0_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend[SRC_T0] |-> grant[SRC_T0]);

    // R8
    entry_masks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && irq_ack && !reg_wr) |=> !gie);

endmodule

// File: tb/irq_vector_ctrl_tb.sv
module irq_vector_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        t0_ovf = 1'b0, t1_ovf = 1'b0, t2_ovf = 1'b0, tb_tick = 1'b0;
    logic        stack_full = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [7:0]  reg_wdata = 8'h00;
    logic [7:0]  reg_rdata;
    logic        irq_req;
    logic [11:0] irq_vec;
    logic        irq_ack = 1'b0;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    irq_vector_ctrl u_dut (
        .clk(clk), .rst_n(rst_n),
        .t0_ovf(t0_ovf), .t1_ovf(t1_ovf), .t2_ovf(t2_ovf), .tb_tick(tb_tick),
        .stack_full(stack_full),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_req(irq_req), .irq_vec(irq_vec), .irq_ack(irq_ack)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    // all tasks start and end just after a falling edge
    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [1:0] a, input logic [7:0] exp);
        reg_addr = a;
        #1;
        check(tag, {8'h00, reg_rdata}, {8'h00, exp});
    endtask

    task automatic pulse(input int which);
        case (which)
            0: t0_ovf = 1'b1;
            1: t1_ovf = 1'b1;
            2: t2_ovf = 1'b1;
            default: tb_tick = 1'b1;
        endcase
        @(negedge clk);
        t0_ovf = 1'b0; t1_ovf = 1'b0; t2_ovf = 1'b0; tb_tick = 1'b0;
    endtask

    task automatic accept();
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
    endtask

    task automatic t_reset();
        rd_chk("R1 reg0", 2'd0, 8'h00);
        rd_chk("R1 reg1", 2'd1, 8'h00);
        check("R1 irq_req", {15'd0, irq_req}, 16'd0);
    endtask

    task automatic t_flags_sw();
        pulse(0);
        rd_chk("R2 t0 flag set by pulse", 2'd0, 8'h10);
        repeat (2) @(negedge clk);
        check("R4 no req without enables", {15'd0, irq_req}, 16'd0);
        wr(2'd0, 8'h00);
        rd_chk("R2 sw clear", 2'd0, 8'h00);
        wr(2'd0, 8'h20);
        rd_chk("R2 sw force t1 flag", 2'd0, 8'h20);
        wr(2'd0, 8'h00);
    endtask

    task automatic t_direct_t0();
        wr(2'd0, 8'h03);
        pulse(0);
        rd_chk("R2 t0 flag latched", 2'd0, 8'h13);
        check("R4 req not yet", {15'd0, irq_req}, 16'd0);
        @(negedge clk);
        check("R4 req raised", {15'd0, irq_req}, 16'd1);
        check("R5 t0 vector", {4'd0, irq_vec}, 16'h000C);
        repeat (3) @(negedge clk);
        check("R7 req held", {15'd0, irq_req}, 16'd1);
        check("R7 vec held", {4'd0, irq_vec}, 16'h000C);
        accept();
        check("R8 req dropped", {15'd0, irq_req}, 16'd0);
        rd_chk("R8 gie and t0 flag cleared", 2'd0, 8'h02);
    endtask

    task automatic t_stack_full();
        stack_full = 1'b1;
        wr(2'd0, 8'h05);
        pulse(1);
        repeat (3) @(negedge clk);
        check("R4 blocked by stack_full", {15'd0, irq_req}, 16'd0);
        stack_full = 1'b0;
        @(negedge clk);
        check("R4 req after stack frees", {15'd0, irq_req}, 16'd1);
        check("R5 t1 vector", {4'd0, irq_vec}, 16'h0010);
        accept();
        rd_chk("R8 t1 flag cleared", 2'd0, 8'h04);
    endtask

    task automatic t_priority();
        wr(2'd0, 8'h36);
        wr(2'd0, 8'h37);
        check("R10 not before next edge", {15'd0, irq_req}, 16'd0);
        @(negedge clk);
        check("R6 t0 wins", {4'd0, irq_vec}, 16'h000C);
        accept();
        rd_chk("R8 only t0 flag cleared", 2'd0, 8'h26);
        check("R8 no req while gie low", {15'd0, irq_req}, 16'd0);
        wr(2'd0, 8'h27);
        @(negedge clk);
        check("R10 pending taken after re-enable", {15'd0, irq_req}, 16'd1);
        check("R6 t1 next", {4'd0, irq_vec}, 16'h0010);
        accept();
        rd_chk("R8 t1 cleared", 2'd0, 8'h06);
    endtask

    task automatic t_shared();
        wr(2'd1, 8'h03);
        wr(2'd0, 8'h09);
        pulse(2);
        rd_chk("R3 aggregate set", 2'd0, 8'h49);
        rd_chk("R3 t2 flag set", 2'd1, 8'h13);
        @(negedge clk);
        check("R4 shared req", {15'd0, irq_req}, 16'd1);
        check("R5 shared vector", {4'd0, irq_vec}, 16'h0018);
        accept();
        rd_chk("R9 aggregate cleared", 2'd0, 8'h08);
        rd_chk("R9 t2 flag kept", 2'd1, 8'h13);
        wr(2'd0, 8'h09);
        repeat (2) @(negedge clk);
        check("R9 sub flag raises nothing", {15'd0, irq_req}, 16'd0);
        rd_chk("R9 t2 flag still kept", 2'd1, 8'h13);
        wr(2'd0, 8'h08);
        wr(2'd1, 8'h03);
        rd_chk("R9 sw clears sub flag", 2'd1, 8'h03);
    endtask

    task automatic t_shared_gate();
        wr(2'd0, 8'h00);
        pulse(3);
        rd_chk("R3 tb flag set", 2'd1, 8'h23);
        rd_chk("R3 no aggregate w/o shared enable", 2'd0, 8'h00);
        wr(2'd1, 8'h01);
        wr(2'd0, 8'h08);
        pulse(3);
        rd_chk("R3 tb flag set again", 2'd1, 8'h21);
        rd_chk("R3 no aggregate w/o tb enable", 2'd0, 8'h08);
        wr(2'd1, 8'h03);
        pulse(3);
        rd_chk("R3 aggregate with both enables", 2'd0, 8'h48);
        check("R4 no req w/o gie", {15'd0, irq_req}, 16'd0);
        wr(2'd0, 8'h00);
        wr(2'd1, 8'h00);
    endtask

    task automatic t_race();
        wr(2'd0, 8'h20);
        t1_ovf = 1'b1;
        wr(2'd0, 8'h00);
        t1_ovf = 1'b0;
        rd_chk("R11 event beats clearing write", 2'd0, 8'h20);
        wr(2'd0, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_flags_sw();
        t_direct_t0();
        t_stack_full();
        t_priority();
        t_shared();
        t_shared_gate();
        t_race();
        report();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog R1-flow actual=timeout expected=completion");
        report();
    end

endmodule